// File: doc/BRIEF.md
# Subaddress Message Activity Tracker

This block keeps per-subaddress bookkeeping for a serial-bus remote terminal. A command decoder tells it when a valid command has been recognised, passing the command word and the address of that command's descriptor. A message engine tells it when a message has finished, passing the subaddress, whether the message was broadcast, and whether it ended a multi-message block transfer. From these the tracker keeps an activity indication, the last command and descriptor address, and an accessed flag for each subaddress. It then decides whether the finished message should raise a message interrupt request toward an interrupt controller.

A host reaches the control words and two read-only status registers through a simple synchronous read/write port. Each control word selects an interrupt policy for its subaddress. The host can also leave interrupts off and poll the accessed flags instead. Reading a control word clears its flag, so a set flag means that at least one message has completed since the previous read.

Top module: `sat_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, `active`, `msg_irq` and `host_rdata` are 0. Every control word reads 0, and both status registers read 0.
- R2: A host write (`host_en`=1, `host_wr`=1) to address 0..31 stores `host_wdata[1:0]` as the policy and `host_wdata[2]` as the block-mode bit of that subaddress. A read returns the policy in bits [1:0], block mode in bit 2, the accessed flag in bit 15 and zero in all other bits. Write data in bit 15 and the other unused bits has no effect.
- R3: A host read (`host_en`=1, `host_wr`=0) places the addressed value on `host_rdata` on the clock edge where it is sampled. `host_rdata` holds that value until the next read. Addresses 34..63 read as zero.
- R4: A message completion (`msg_done`=1) sets the accessed flag of subaddress `msg_sa` and no other flag.
- R5: A host read of a control word returns the flag's value from before that edge and clears the flag. If a message completes for the same subaddress in the same cycle, the flag stays set.
- R6: With policy 01 (every), a message completion raises `msg_irq` for exactly the following cycle.
- R7: With policy 10 (broadcast), `msg_irq` is raised only when `msg_bcast` is 1 at completion.
- R8: With policy 11 (end of block), `msg_irq` is raised only when `msg_eob` is 1 and the block-mode bit is set. With block mode clear, the policy never interrupts.
- R9: With policy 00 (none), and in any cycle after which `msg_done` was 0, `msg_irq` is 0. The decision uses the policy stored before a same-cycle host write.
- R10: On `cmd_valid` the command word and descriptor address are captured. They read back at addresses 32 and 33 (zero-extended) and hold until the next `cmd_valid`.
- R11: `active` rises in the cycle after `cmd_valid` and falls in the cycle after `msg_done`. When both arrive together, `active` is 1.
- R12: Host writes to addresses 32..63 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a valid command was decoded |
| cmd_word | input | CMD_W | Decoded command word |
| cmd_desc | input | DESC_W | Descriptor address of the decoded command |
| msg_done | input | 1 | One-cycle strobe: message processing finished |
| msg_sa | input | SA_W | Subaddress of the finished message |
| msg_bcast | input | 1 | Finished message was broadcast |
| msg_eob | input | 1 | Finished message ended a block transfer |
| host_en | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | SA_W+1 | 0..31 control words, 32 command, 33 descriptor address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| active | output | 1 | High while a command is in progress |
| msg_irq | output | 1 | One-cycle message interrupt request |

## Verification
The bench uses the default parameters: 32 subaddresses, 16-bit data, command and descriptor fields, and a 6-bit host address. With these values every control word, both status registers and the unused upper addresses can all be reached. Directed phases set up each policy with block mode both on and off, and exercise a read that collides with a completion, a completion that coincides with a command, and writes into the status range. A long random phase then mixes all strobes against the reference model, so reads, writes and completions on the same subaddress collide often.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    POL_NONE  = 2'b00,
    POL_EVERY = 2'b01,
    POL_BCAST = 2'b10,
    POL_EOB   = 2'b11
  } sat_policy_e;

  typedef struct packed {
    logic        acc;
    logic        blk;
    sat_policy_e pol;
  } sat_cw_t;

  localparam int BLK_BIT = 2;
endpackage

// File: rtl/sat_ctrl_bank.sv
module sat_ctrl_bank
  import sat_pkg::*;
#(
  parameter int SA_COUNT = 32,
  parameter int SA_W     = $clog2(SA_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SA_W-1:0]   host_idx,
  input  sat_policy_e       wr_pol,
  input  logic              wr_blk,
  input  logic              set_en,
  input  logic [SA_W-1:0]   set_idx,
  output sat_cw_t           rd_cw,
  output sat_cw_t           msg_cw
);
  sat_cw_t cw_q [SA_COUNT];

  for (genvar gi = 0; gi < SA_COUNT; gi++) begin : g_entry
    localparam logic [SA_W-1:0] MY_IDX = SA_W'(gi);
    logic    hit_wr, hit_rd, hit_set;
    sat_cw_t cw_d;

    assign hit_wr  = wr_en  && (host_idx == MY_IDX);
    assign hit_rd  = rd_en  && (host_idx == MY_IDX);
    assign hit_set = set_en && (set_idx  == MY_IDX);

    always_comb begin
      cw_d = cw_q[gi];
      if (hit_wr) begin
        cw_d.pol = wr_pol;
        cw_d.blk = wr_blk;
      end
      if (hit_set)     cw_d.acc = 1'b1;
      else if (hit_rd) cw_d.acc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cw_q[gi] <= '0;
      else        cw_q[gi] <= cw_d;
    end
  end

  assign rd_cw  = cw_q[host_idx];
  assign msg_cw = cw_q[set_idx];
endmodule

// File: rtl/sat_irq_eval.sv
module sat_irq_eval
  import sat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  sat_policy_e pol,
  input  logic        blk,
  input  logic        bcast,
  input  logic        eob,
  output logic        irq
);
  logic fire_d, irq_q;

  always_comb begin
    unique case (pol)
      POL_EVERY: fire_d = done;
      POL_BCAST: fire_d = done && bcast;
      POL_EOB:   fire_d = done && eob && blk;
      default:   fire_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/sat_cmd_capture.sv
module sat_cmd_capture #(
  parameter int CMD_W  = 16,
  parameter int DESC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [DESC_W-1:0] cmd_desc,
  input  logic              msg_done,
  output logic [CMD_W-1:0]  cur_cmd,
  output logic [DESC_W-1:0] cur_desc,
  output logic              active
);
  logic [CMD_W-1:0]  cmd_q;
  logic [DESC_W-1:0] desc_q;
  logic              act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (cmd_valid)     act_d = 1'b1;
    else if (msg_done) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      desc_q <= '0;
    end else if (cmd_valid) begin
      cmd_q  <= cmd_word;
      desc_q <= cmd_desc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign cur_cmd  = cmd_q;
  assign cur_desc = desc_q;
  assign active   = act_q;
endmodule

// File: rtl/sat_tracker.sv
module sat_tracker
  import sat_pkg::*;
#(
  parameter int SA_COUNT = 32,
  parameter int SA_W     = $clog2(SA_COUNT),
  parameter int DATA_W   = 16,
  parameter int CMD_W    = 16,
  parameter int DESC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [DESC_W-1:0] cmd_desc,
  input  logic              msg_done,
  input  logic [SA_W-1:0]   msg_sa,
  input  logic              msg_bcast,
  input  logic              msg_eob,
  input  logic              host_en,
  input  logic              host_wr,
  input  logic [SA_W:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              active,
  output logic              msg_irq
);
  localparam int ACC_BIT = DATA_W - 1;
  localparam logic [SA_W-1:0] STAT_CMD  = SA_W'(0);
  localparam logic [SA_W-1:0] STAT_DESC = SA_W'(1);

  logic              in_status, host_rd, cw_wr, cw_rd;
  sat_cw_t           rd_cw, msg_cw;
  logic [CMD_W-1:0]  cur_cmd;
  logic [DESC_W-1:0] cur_desc;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign in_status = host_addr[SA_W];
  assign host_rd   = host_en && !host_wr;
  assign cw_wr     = host_en && host_wr && !in_status;
  assign cw_rd     = host_rd && !in_status;

  sat_ctrl_bank #(.SA_COUNT(SA_COUNT), .SA_W(SA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cw_wr),
    .rd_en    (cw_rd),
    .host_idx (host_addr[SA_W-1:0]),
    .wr_pol   (sat_policy_e'(host_wdata[1:0])),
    .wr_blk   (host_wdata[BLK_BIT]),
    .set_en   (msg_done),
    .set_idx  (msg_sa),
    .rd_cw    (rd_cw),
    .msg_cw   (msg_cw)
  );

  sat_irq_eval u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (msg_done),
    .pol   (msg_cw.pol),
    .blk   (msg_cw.blk),
    .bcast (msg_bcast),
    .eob   (msg_eob),
    .irq   (msg_irq)
  );

  sat_cmd_capture #(.CMD_W(CMD_W), .DESC_W(DESC_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .cmd_desc  (cmd_desc),
    .msg_done  (msg_done),
    .cur_cmd   (cur_cmd),
    .cur_desc  (cur_desc),
    .active    (active)
  );

  always_comb begin
    rdata_d = '0;
    if (!in_status) begin
      rdata_d[1:0]    = rd_cw.pol;
      rdata_d[BLK_BIT] = rd_cw.blk;
      rdata_d[ACC_BIT] = rd_cw.acc;
    end else if (host_addr[SA_W-1:0] == STAT_CMD) begin
      rdata_d = DATA_W'(cur_cmd);
    end else if (host_addr[SA_W-1:0] == STAT_DESC) begin
      rdata_d = DATA_W'(cur_desc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rdata_d;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/sat_tracker_chk.sv
module sat_tracker_chk
  import sat_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             msg_done,
  input logic             msg_bcast,
  input logic             msg_eob,
  input sat_policy_e      msg_pol,
  input logic             msg_blk,
  input logic [CMD_W-1:0] cur_cmd,
  input logic             active,
  input logic             msg_irq
);
  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!active && !msg_irq);
    end
  end

  // R9
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_irq |-> $past(msg_done));

  // R9
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && msg_pol == POL_NONE) |=> !msg_irq);

  // R6
  every_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && msg_pol == POL_EVERY) |=> msg_irq);

  // R7
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && msg_pol == POL_BCAST && !msg_bcast) |=> !msg_irq);

  // R8
  eob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && msg_pol == POL_EOB && !(msg_eob && msg_blk)) |=> !msg_irq);

  // R11
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> active);

  // R11
  active_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && !cmd_valid) |=> !active);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(cur_cmd));
endmodule

bind sat_tracker sat_tracker_chk #(.CMD_W(CMD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .msg_done  (msg_done),
  .msg_bcast (msg_bcast),
  .msg_eob   (msg_eob),
  .msg_pol   (msg_cw.pol),
  .msg_blk   (msg_cw.blk),
  .cur_cmd   (cur_cmd),
  .active    (active),
  .msg_irq   (msg_irq)
);

// File: tb/tb_sat_tracker.sv
module tb_sat_tracker;
  localparam int NSA = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0;
  logic [15:0] cmd_word = 0;
  logic [15:0] cmd_desc = 0;
  logic        msg_done = 0;
  logic [4:0]  msg_sa = 0;
  logic        msg_bcast = 0;
  logic        msg_eob = 0;
  logic        host_en = 0;
  logic        host_wr = 0;
  logic [5:0]  host_addr = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic        active;
  logic        msg_irq;

  always #10 clk = ~clk;

  sat_tracker dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_desc(cmd_desc), .msg_done(msg_done), .msg_sa(msg_sa),
    .msg_bcast(msg_bcast), .msg_eob(msg_eob), .host_en(host_en),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .active(active), .msg_irq(msg_irq)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    finished = 0;
  string req = "R1";

  int m_pol [NSA];
  int m_blk [NSA];
  int m_acc [NSA];
  int m_cmd = 0, m_desc = 0, m_act = 0, m_irq = 0, m_rdata = 0;

  function automatic int cw_val(int i);
    return (m_acc[i] << 15) | (m_blk[i] << 2) | m_pol[i];
  endfunction

  task automatic model_step();
    int a = host_addr;
    int fire;
    if (host_en && !host_wr) begin
      if (a < 32)       m_rdata = cw_val(a);
      else if (a == 32) m_rdata = m_cmd;
      else if (a == 33) m_rdata = m_desc;
      else              m_rdata = 0;
    end
    fire = 0;
    if (msg_done) begin
      case (m_pol[msg_sa])
        1: fire = 1;
        2: fire = msg_bcast;
        3: fire = msg_eob && m_blk[msg_sa];
        default: fire = 0;
      endcase
    end
    m_irq = fire;
    if (host_en && !host_wr && a < 32) m_acc[a] = 0;
    if (msg_done) m_acc[msg_sa] = 1;
    if (host_en && host_wr && a < 32) begin
      m_pol[a] = host_wdata[1:0];
      m_blk[a] = host_wdata[2];
    end
    if (cmd_valid) begin
      m_cmd  = cmd_word;
      m_desc = cmd_desc;
    end
    if (cmd_valid)     m_act = 1;
    else if (msg_done) m_act = 0;
  endtask

  task automatic compare();
    n_cmp += 3;
    if (host_rdata !== 16'(m_rdata)) begin
      n_bad++;
      $display("FAIL %s host_rdata actual %h expected %h", req, host_rdata, 16'(m_rdata));
    end
    if (msg_irq !== 1'(m_irq)) begin
      n_bad++;
      $display("FAIL %s msg_irq actual %0b expected %0b", req, msg_irq, m_irq);
    end
    if (active !== 1'(m_act)) begin
      n_bad++;
      $display("FAIL %s active actual %0b expected %0b", req, active, m_act);
    end
  endtask

  task automatic idle_inputs();
    cmd_valid = 0; msg_done = 0; msg_bcast = 0; msg_eob = 0;
    host_en = 0; host_wr = 0;
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare();
    idle_inputs();
  endtask

  task automatic hwrite(int a, int d);
    host_en = 1; host_wr = 1; host_addr = 6'(a); host_wdata = 16'(d);
    step();
  endtask

  task automatic hread(int a);
    host_en = 1; host_wr = 0; host_addr = 6'(a);
    step();
  endtask

  task automatic done(int sa, bit bc, bit eb);
    msg_done = 1; msg_sa = 5'(sa); msg_bcast = bc; msg_eob = eb;
    step();
  endtask

  task automatic command(int w, int d);
    cmd_valid = 1; cmd_word = 16'(w); cmd_desc = 16'(d);
    step();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired in %s", req);
    summary();
  end

  initial begin
    for (int i = 0; i < NSA; i++) begin
      m_pol[i] = 0; m_blk[i] = 0; m_acc[i] = 0;
    end
    // R1: outputs during reset and after release
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    @(negedge clk);
    compare();
    hread(0); hread(31); hread(32); hread(33);

    // R2: write with junk in unused bits, read back
    req = "R2";
    hwrite(3, 16'hFFF9);
    hread(3);
    hwrite(1, 1); hwrite(2, 2); hwrite(4, 7); hwrite(6, 3); hwrite(0, 0);
    for (int i = 0; i < 8; i++) hread(i);

    // R3: unused upper addresses and hold of rdata
    req = "R3";
    hread(40); hread(63);
    step(); step();

    // R10 / R11: command then completion
    req = "R10";
    command(16'h1234, 16'h0456);
    hread(32); hread(33);
    req = "R11";
    step();
    done(1, 0, 0);

    // R6: every
    req = "R6";
    done(1, 0, 0); done(1, 1, 1); step();
    // R7: broadcast only
    req = "R7";
    done(2, 0, 0); done(2, 1, 0); step(); done(2, 0, 1);
    // R8: end of block with and without block mode
    req = "R8";
    done(4, 0, 1); done(4, 1, 0); done(6, 0, 1); done(6, 1, 1); step();
    // R9: none policy
    req = "R9";
    done(0, 1, 1); step();
    // R9: same-cycle write does not change this decision
    msg_done = 1; msg_sa = 5; host_en = 1; host_wr = 1; host_addr = 5; host_wdata = 1;
    step();
    done(5, 0, 0);

    // R4: flags of others untouched
    req = "R4";
    hread(9); done(9, 0, 0); hread(9); hread(10); hread(9);
    // R5: collision of read and completion
    req = "R5";
    done(12, 0, 0);
    msg_done = 1; msg_sa = 12; host_en = 1; host_wr = 0; host_addr = 12;
    step();
    hread(12); hread(12);
    msg_done = 1; msg_sa = 13; host_en = 1; host_wr = 0; host_addr = 12;
    step();
    hread(13);

    // R11: command coinciding with completion keeps active high
    req = "R11";
    command(16'hAAAA, 16'h5555);
    cmd_valid = 1; cmd_word = 16'hBEEF; cmd_desc = 16'h0F0F; msg_done = 1; msg_sa = 1;
    step();
    step();
    done(3, 0, 0);
    step();

    // R12: writes into status range ignored
    req = "R12";
    hwrite(32, 16'h0000); hwrite(33, 16'hFFFF); hwrite(50, 16'hFFFF);
    hread(32); hread(33); hread(50);
    for (int i = 0; i < 8; i++) hread(i);

    // random mix across all requirements
    req = "R4/R5/R6/R7/R8 random";
    for (int n = 0; n < 4000; n++) begin
      cmd_valid = ($urandom_range(0, 7) == 0);
      cmd_word  = 16'($urandom);
      cmd_desc  = 16'($urandom);
      msg_done  = ($urandom_range(0, 2) == 0);
      msg_sa    = 5'($urandom_range(0, 7));
      msg_bcast = 1'($urandom);
      msg_eob   = 1'($urandom);
      host_en   = 1'($urandom);
      host_wr   = ($urandom_range(0, 3) == 0);
      host_addr = ($urandom_range(0, 9) == 0) ? 6'($urandom_range(32, 63))
                                              : 6'($urandom_range(0, 7));
      host_wdata = 16'($urandom);
      step();
    end
    summary();
  end
endmodule